// File: doc/BRIEF.md
# Dual-Channel Converter Power Mode Sequencer

This block decides, cycle by cycle, which channel of a two-channel converter's digital back-end is running and when the data of each channel can be trusted. It is driven by the sample clock and three controls: an active-low chip power-down line and a two-bit active-low sleep bus, with one bit for each channel. For each channel it reports three flags. `ch_active` means the channel is powered and clocked. `ch_ready` means the channel's slow internal settling is done, so a wake from sleep is short. `ch_valid` means the channel's startup wait is over and its samples may be used.

Power-down overrides everything else and clears all flags. After power-down is released, a channel that is awake waits `PD_START` sample clocks before its data is valid. A channel woken from sleep that is still settled waits only `SLP_START` clocks. If sleep or power-down comes back before a wait completes, the wait is dropped and starts again from zero on the next wake.

After a synchronous reset the block is locked. A power-down pulse must be seen before any channel may become active.

The lock controller has three states:
- `LK_LOCKED`: the state after reset.
- `LK_DOWN`: power-down is being held.
- `LK_RUN`: channels are enabled.

Its transitions are:
- LOCKED→DOWN and RUN→DOWN when power-down is sampled low.
- DOWN→RUN when power-down is sampled high.

Each channel sequencer has four states:
- `CH_OFF`: no power.
- `CH_SLEEP`: powered down by its sleep bit.
- `CH_WARM`: counting its startup wait.
- `CH_ON`: data valid.

Its transitions are:
- Any state goes to OFF on power-down, or when the lock controller is not in RUN.
- OFF or SLEEP goes to WARM when the sleep bit is 1, and from OFF to SLEEP when the bit is 0.
- WARM goes to SLEEP when the sleep bit is 0.
- WARM goes to ON on the last count.
- ON goes to SLEEP when the sleep bit is 0.

Top module: `adc_mode_ctrl`

## Requirements
- R1: When `pwr_dn_n` is sampled low at a clock edge, all bits of `ch_active`, `ch_valid` and `ch_ready` are 0 after that edge, whatever `slp_n` holds.
- R2: After reset, all outputs stay 0 until `pwr_dn_n` has been sampled low at least once and then sampled high. `ch_active` rises at the second edge after the first high sample.
- R3: Bit i of `slp_n` is channel i's wake bit: 00 means both channels sleep, 01 means only channel 0 runs, 10 means only channel 1 runs, and 11 means both run. A channel whose bit is sampled 0 has `ch_active` low after that edge.
- R4: With the block enabled, a channel whose wake bit is sampled 1 while it is off or asleep has `ch_active` high after that edge.
- R5: A channel with `ch_ready` low has `ch_valid` rise exactly `PD_START` (default 900) edges after `ch_active` rises.
- R6: A channel with `ch_ready` high has `ch_valid` rise exactly `SLP_START` (default 20) edges after `ch_active` rises.
- R7: `ch_ready` of a channel rises together with its `ch_valid`. It stays high through sleep and is cleared only by power-down or reset.
- R8: If a channel is put to sleep or powered down before its wait completes, the partial count is discarded. The next wake waits the full length again.
- R9: `ch_valid` is high only while `ch_active` is high, after the channel's wait has expired.
- R10: A synchronous active-high `rst` clears all outputs at the next edge and returns the block to the locked state.
- R11: Putting one channel to sleep or waking it leaves the other channel's `ch_active`, `ch_valid` and `ch_ready` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; returns to the locked state |
| pwr_dn_n | input | 1 | Chip power-down, active low; overrides all other controls |
| slp_n | input | NUM_CH | Per-channel wake bits, active-low sleep; bit i is channel i |
| ch_active | output | NUM_CH | Channel i is powered and clocked |
| ch_ready | output | NUM_CH | Channel i has settled; the next wake uses the short wait |
| ch_valid | output | NUM_CH | Channel i's startup wait has expired; data usable |

## Verification
Every flag is a registered state decode, so each result is due a fixed number of edges after the stimulus:
- A sleep-bit or power-down change shows one edge later.
- A power-down release shows at `ch_active` two edges later, because the lock controller must first reach RUN.
- `ch_valid` follows `ch_active` by exactly `PD_START` or `SLP_START` edges.

The bench drives inputs on falling edges and samples on falling edges. Each directed check waits exactly the counted number of edges, with one sample just before the due edge and one just after it. A behavioural model with countdown integers is also compared on every falling edge. That comparison catches a flag that moves at the wrong moment even where no directed check is placed.

// File: rtl/adc_mode_pkg.sv
package adc_mode_pkg;

    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_DOWN   = 2'd1,
        LK_RUN    = 2'd2
    } lock_state_t;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_SLEEP = 2'd1,
        CH_WARM  = 2'd2,
        CH_ON    = 2'd3
    } chan_state_t;

endpackage

// File: rtl/adc_lock_fsm.sv
module adc_lock_fsm
    import adc_mode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pd_req,
    output logic run_en
);

    lock_state_t state_q;
    lock_state_t state_d;

    // next state: the lock is released only by a full power-down pulse
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (pd_req) state_d = LK_DOWN;
            LK_DOWN:   if (!pd_req) state_d = LK_RUN;
            LK_RUN:    if (pd_req) state_d = LK_DOWN;
            default:   state_d = LK_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LK_LOCKED;
        else     state_q <= state_d;
    end

    always_comb begin
        run_en = (state_q == LK_RUN);
    end

endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
    import adc_mode_pkg::*;
#(
    parameter int PD_START  = 900,
    parameter int SLP_START = 20,
    parameter int CNT_W     = 10
)(
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic pd_req,
    input  logic wake,
    output logic active,
    output logic valid,
    output logic ready
);

    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(PD_START - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SLP_START - 1);

    chan_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              rdy_q, rdy_d;
    logic [CNT_W-1:0]  last_cnt;

    // a settled channel only needs the short wait
    always_comb begin
        last_cnt = rdy_q ? SHORT_LAST : LONG_LAST;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rdy_d   = rdy_q;
        if (pd_req || !run_en) begin
            state_d = CH_OFF;
            cnt_d   = '0;
            rdy_d   = 1'b0;
        end else begin
            unique case (state_q)
                CH_OFF, CH_SLEEP: begin
                    cnt_d = '0;
                    if (wake) state_d = CH_WARM;
                    else      state_d = CH_SLEEP;
                end
                CH_WARM: begin
                    if (!wake) begin
                        state_d = CH_SLEEP;
                        cnt_d   = '0;
                    end else if (cnt_q == last_cnt) begin
                        state_d = CH_ON;
                        cnt_d   = '0;
                        rdy_d   = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                CH_ON: begin
                    if (!wake) state_d = CH_SLEEP;
                end
                default: state_d = CH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_OFF;
            cnt_q   <= '0;
            rdy_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rdy_q   <= rdy_d;
        end
    end

    always_comb begin
        active = (state_q == CH_WARM) || (state_q == CH_ON);
        valid  = (state_q == CH_ON);
        ready  = rdy_q;
    end

endmodule

// File: rtl/adc_mode_ctrl.sv
module adc_mode_ctrl #(
    parameter int NUM_CH    = 2,
    parameter int PD_START  = 900,
    parameter int SLP_START = 20
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn_n,
    input  logic [NUM_CH-1:0] slp_n,
    output logic [NUM_CH-1:0] ch_active,
    output logic [NUM_CH-1:0] ch_ready,
    output logic [NUM_CH-1:0] ch_valid
);

    localparam int CNT_W = $clog2(PD_START + 1);

    logic pd_req;
    logic run_en;

    assign pd_req = !pwr_dn_n;

    adc_lock_fsm u_lock (
        .clk    (clk),
        .rst    (rst),
        .pd_req (pd_req),
        .run_en (run_en)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        adc_chan_seq #(
            .PD_START  (PD_START),
            .SLP_START (SLP_START),
            .CNT_W     (CNT_W)
        ) u_seq (
            .clk    (clk),
            .rst    (rst),
            .run_en (run_en),
            .pd_req (pd_req),
            .wake   (slp_n[g]),
            .active (ch_active[g]),
            .valid  (ch_valid[g]),
            .ready  (ch_ready[g])
        );
    end

endmodule

// File: rtl/adc_mode_chk.sv
module adc_mode_chk #(
    parameter int NUM_CH   = 2,
    parameter int PD_START = 900
)(
    input logic              clk,
    input logic              rst,
    input logic              pwr_dn_n,
    input logic [NUM_CH-1:0] slp_n,
    input logic [NUM_CH-1:0] ch_active,
    input logic [NUM_CH-1:0] ch_ready,
    input logic [NUM_CH-1:0] ch_valid
);

    localparam int RW = $clog2(PD_START + 2);

    logic seen_pd;

    always_ff @(posedge clk) begin
        if (rst)            seen_pd <= 1'b0;
        else if (!pwr_dn_n) seen_pd <= 1'b1;
    end

    // R2: no channel runs before a power-down has been observed
    p_locked_r2: assert property (@(posedge clk) disable iff (rst)
        !seen_pd |-> (ch_active == '0));

    // R1: power-down clears every flag at the following edge
    p_pd_clear_r1: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn_n |=> (ch_active == '0 && ch_valid == '0 && ch_ready == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        logic [RW-1:0] warm_q;

        always_ff @(posedge clk) begin
            if (rst)                            warm_q <= '0;
            else if (ch_active[g] && !ch_valid[g]) warm_q <= warm_q + RW'(1);
            else                                warm_q <= '0;
        end

        // R9: valid only with active
        p_valid_active_r9: assert property (@(posedge clk) disable iff (rst)
            ch_valid[g] |-> ch_active[g]);

        // R3: a sleep bit of 0 turns the channel off at the next edge
        p_sleep_off_r3: assert property (@(posedge clk) disable iff (rst)
            !slp_n[g] |=> !ch_active[g]);

        // R7: ready only falls through power-down
        p_ready_hold_r7: assert property (@(posedge clk) disable iff (rst)
            (ch_ready[g] && pwr_dn_n) |=> ch_ready[g]);

        // R7: valid rises together with ready
        p_ready_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_valid[g]) |-> ch_ready[g]);

        // R5: the startup wait never exceeds the long count
        p_warm_bound_r5: assert property (@(posedge clk) disable iff (rst)
            warm_q <= RW'(PD_START));
    end

endmodule

bind adc_mode_ctrl adc_mode_chk #(
    .NUM_CH   (NUM_CH),
    .PD_START (PD_START)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_dn_n  (pwr_dn_n),
    .slp_n     (slp_n),
    .ch_active (ch_active),
    .ch_ready  (ch_ready),
    .ch_valid  (ch_valid)
);

// File: tb/sim_adc_mode_ctrl.sv
`timescale 1ns/1ps
module sim_adc_mode_ctrl;

    localparam int NCH = 2;
    localparam int PDS = 900;
    localparam int SLS = 20;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           pwr_dn_n = 1'b1;
    logic [NCH-1:0] slp_n = 2'b11;
    logic [NCH-1:0] ch_active, ch_ready, ch_valid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string cur_req = "R10";
    bit started = 0;

    always #4 clk = ~clk;

    adc_mode_ctrl #(.NUM_CH(NCH), .PD_START(PDS), .SLP_START(SLS)) u0 (
        .clk(clk), .rst(rst), .pwr_dn_n(pwr_dn_n), .slp_n(slp_n),
        .ch_active(ch_active), .ch_ready(ch_ready), .ch_valid(ch_valid)
    );

    // behavioural reference: lock 0 locked, 1 down, 2 run; mode 0 off, 1 sleep, 2 warm, 3 on
    int m_lock = 0;
    int m_mode [NCH];
    int m_rem  [NCH];
    bit m_rdy  [NCH];

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_mode[c] = 0; m_rem[c] = 0; m_rdy[c] = 0;
        end
    end

    always @(posedge clk) begin
        bit en_old;
        bit pd;
        started = 1;
        if (rst) begin
            m_lock = 0;
            for (int c = 0; c < NCH; c++) begin
                m_mode[c] = 0; m_rem[c] = 0; m_rdy[c] = 0;
            end
        end else begin
            en_old = (m_lock == 2);
            pd = !pwr_dn_n;
            if (pd) m_lock = 1;
            else if (m_lock == 1) m_lock = 2;
            for (int c = 0; c < NCH; c++) begin
                if (pd || !en_old) begin
                    m_mode[c] = 0; m_rdy[c] = 0;
                end else if (!slp_n[c]) begin
                    m_mode[c] = 1;
                end else if (m_mode[c] < 2) begin
                    m_mode[c] = 2;
                    m_rem[c] = m_rdy[c] ? SLS : PDS;
                end else if (m_mode[c] == 2) begin
                    m_rem[c] = m_rem[c] - 1;
                    if (m_rem[c] == 0) begin
                        m_mode[c] = 3; m_rdy[c] = 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        logic [NCH-1:0] ea, ev, er;
        if (started) begin
            for (int c = 0; c < NCH; c++) begin
                ea[c] = (m_mode[c] >= 2);
                ev[c] = (m_mode[c] == 3);
                er[c] = m_rdy[c];
            end
            checks++;
            if (ch_active !== ea || ch_valid !== ev || ch_ready !== er) begin
                fails++;
                $display("FAIL %s model: actual a=%b v=%b r=%b expected a=%b v=%b r=%b",
                         cur_req, ch_active, ch_valid, ch_ready, ea, ev, er);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [NCH-1:0] act, logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk_all_zero(string req);
        chk(req, "active", ch_active, 2'b00);
        chk(req, "valid",  ch_valid,  2'b00);
        chk(req, "ready",  ch_ready,  2'b00);
    endtask

    initial begin
        // R10: reset state
        step(3);
        chk_all_zero("R10");
        rst = 1'b0;

        // R2: locked although awake and not powered down
        cur_req = "R2";
        step(40);
        chk_all_zero("R2");

        // R1: power-down pulse
        cur_req = "R1";
        pwr_dn_n = 1'b0;
        step(5);
        chk_all_zero("R1");

        // R2/R4/R5: release, active at second edge, valid after long wait
        cur_req = "R5";
        pwr_dn_n = 1'b1;
        step(1);
        chk("R2", "active one edge after release", ch_active, 2'b00);
        step(1);
        chk("R4", "active two edges after release", ch_active, 2'b11);
        chk("R5", "valid at start", ch_valid, 2'b00);
        step(PDS - 1);
        chk("R5", "valid one edge early", ch_valid, 2'b00);
        chk("R7", "ready one edge early", ch_ready, 2'b00);
        step(1);
        chk("R5", "valid on time", ch_valid, 2'b11);
        chk("R7", "ready with valid", ch_ready, 2'b11);

        // R3/R11: code 01 keeps only channel 0
        cur_req = "R3";
        slp_n = 2'b01;
        step(1);
        chk("R3", "active code 01", ch_active, 2'b01);
        chk("R11", "valid ch0 untouched", ch_valid, 2'b01);
        chk("R7", "ready held in sleep", ch_ready, 2'b11);

        // R6: short wake of channel 1
        cur_req = "R6";
        slp_n = 2'b11;
        step(1);
        chk("R4", "active after wake", ch_active, 2'b11);
        step(SLS - 1);
        chk("R6", "valid one edge early", ch_valid, 2'b01);
        step(1);
        chk("R6", "valid on time", ch_valid, 2'b11);

        // R8: sleep mid-count restarts the wait
        cur_req = "R8";
        slp_n = 2'b10;
        step(3);
        chk("R3", "active code 10", ch_active, 2'b10);
        slp_n = 2'b11;
        step(10);
        slp_n = 2'b10;
        step(1);
        chk("R8", "dropped mid-count", ch_active, 2'b10);
        chk("R11", "valid ch1 untouched", ch_valid, 2'b10);
        slp_n = 2'b11;
        step(1);
        chk("R8", "active on rewake", ch_active, 2'b11);
        step(SLS - 1);
        chk("R8", "no credit from partial count", ch_valid, 2'b10);
        step(1);
        chk("R8", "valid after full wait", ch_valid, 2'b11);

        // R3: code 00 sleeps both, ready kept
        cur_req = "R3";
        slp_n = 2'b00;
        step(1);
        chk("R3", "active code 00", ch_active, 2'b00);
        chk("R3", "valid code 00", ch_valid, 2'b00);
        chk("R7", "ready kept code 00", ch_ready, 2'b11);
        slp_n = 2'b10;
        step(1);
        chk("R3", "active code 10 from 00", ch_active, 2'b10);
        step(SLS - 1);
        chk("R6", "ch1 short wait early", ch_valid, 2'b00);
        step(1);
        chk("R6", "ch1 short wait on time", ch_valid, 2'b10);

        // R1/R7: power-down while running clears ready
        cur_req = "R1";
        slp_n = 2'b11;
        pwr_dn_n = 1'b0;
        step(1);
        chk_all_zero("R1");

        // R5: release asleep, then wake uses long wait
        cur_req = "R5";
        pwr_dn_n = 1'b1;
        slp_n = 2'b00;
        step(30);
        chk_all_zero("R7");
        slp_n = 2'b11;
        step(1);
        chk("R4", "active after wake from fresh", ch_active, 2'b11);
        step(PDS - 1);
        chk("R5", "long wait early", ch_valid, 2'b00);
        step(1);
        chk("R5", "long wait on time", ch_valid, 2'b11);

        // R8: power-down mid-count restarts the long wait
        cur_req = "R8";
        pwr_dn_n = 1'b0;
        step(2);
        pwr_dn_n = 1'b1;
        step(2);
        chk("R4", "active after release", ch_active, 2'b11);
        step(500);
        pwr_dn_n = 1'b0;
        step(1);
        chk_all_zero("R1");
        pwr_dn_n = 1'b1;
        step(2);
        chk("R8", "active again", ch_active, 2'b11);
        step(PDS - 1);
        chk("R8", "restarted long wait early", ch_valid, 2'b00);
        step(1);
        chk("R8", "restarted long wait on time", ch_valid, 2'b11);

        // R10: reset relocks
        cur_req = "R10";
        rst = 1'b1;
        step(1);
        chk_all_zero("R10");
        rst = 1'b0;
        step(20);
        chk("R10", "locked after reset", ch_active, 2'b00);
        chk("R2", "no valid while locked", ch_valid, 2'b00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule